// File: doc/BRIEF.md
# Short-Line Clock Stall Equalizer

This block sits between a master clock source and a video-generating system whose horizontal line normally spans 1364 master ticks. On every other frame, one line near the top of the picture runs 4 ticks short, and the whole line is short, not just its sync pulse. The block watches the system's horizontal sync, measures each line in the ticks the system actually received, and withholds the system's clock enable for 4 master ticks when it finds a short line. The stall stops the whole system, so the system cannot see it. Its own interrupt and event order stays regular.

The clock enable is a registered output meant to drive a glitch-free clock gate or the enable pins of the downstream registers. A stall-active flag marks the stalled ticks. A small per-frame tally counts the corrections and clears on each falling edge of vertical sync. A bypass input keeps the enable high at all times.

Top module: `short_line_equalizer`

## Requirements
- R1: While reset is asserted, `clk_en_o` is 1, `stall_o` is 0 and `fix_count_o` is 0.
- R2: Line length is the number of rising clock edges with `clk_en_o` high between two consecutive sampled falling edges of `hsync_i`. Stalled ticks are not counted, so a line that follows a stall is measured at its true length.
- R3: A measured length from 1000 to 1360 inclusive starts exactly one stall after the falling edge that ends that line.
- R4: During a stall, `clk_en_o` is 0 for exactly the 4 cycles that follow the first rising edge that samples `hsync_i` low after a high sample. It is 1 in every other cycle.
- R5: `stall_o` is 1 in exactly the cycles in which a stall holds `clk_en_o` at 0.
- R6: The first falling edge of `hsync_i` after reset only starts a measurement. It never causes a stall.
- R7: A measured length from 1361 to 1500 inclusive is a normal line and causes no stall.
- R8: A measured length below 1000 or above 1500 is treated as a sync glitch and causes no stall.
- R9: When `bypass_i` is sampled high, `clk_en_o` is 1 from the next cycle on, any stall in progress ends, and no new stall starts.
- R10: `fix_count_o` rises by one at each stall start. It clears on the edge that samples `vsync_i` low after a high sample, and a stall starting on that same edge leaves it at 1. It saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync from the downstream system, active low |
| vsync_i | input | 1 | Vertical sync from the downstream system, active low |
| bypass_i | input | 1 | Forces the clock enable high and suppresses corrections |
| clk_en_o | output | 1 | Registered clock enable for the downstream system |
| stall_o | output | 1 | High during the stalled ticks |
| fix_count_o | output | TALLY_W | Corrections made since the last vertical sync falling edge |

## Verification
The enable and the stall flag change one edge after the block samples the sync edge, because that sample and both outputs are registers. The low window therefore covers the 4 cycles after that sampling edge. A bypass takes effect one edge after it is sampled, and the tally updates on the same edge as the stall start or the vertical sync sample. The bench plays the downstream system itself: it advances its sync only on enabled edges, samples every output on the falling clock edge of every cycle of every line, and compares each cycle with a pattern computed from the previous line's length. It reads the tally once each line has ended, after all updates for that line have settled.

// File: rtl/lineq_pkg.sv
package lineq_pkg;

   // Result of one line measurement, produced on the cycle a sync edge is seen
   typedef struct packed {
      logic done;     // a line boundary was sampled
      logic valid;    // measurement armed and inside the plausible range
      logic shortl;   // valid and at or below the short limit
   } line_evt_t;

   function automatic int unsigned bits_for(input int unsigned value);
      return (value < 2) ? 1 : $clog2(value + 1);
   endfunction

endpackage

// File: rtl/lineq_edge.sv
module lineq_edge #(
   parameter bit FALLING = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic edge_o
);

   // Reset the previous sample to the level after the wanted edge, so no edge
   // is reported until the opposite level has been seen once.
   localparam logic PREV_RST = FALLING ? 1'b0 : 1'b1;

   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= PREV_RST;
      else         prev_q <= lvl_i;
   end

   generate
      if (FALLING) begin : g_fall
         assign edge_o = prev_q & ~lvl_i;
      end else begin : g_rise
         assign edge_o = ~prev_q & lvl_i;
      end
   endgenerate

endmodule

// File: rtl/lineq_meter.sv
module lineq_meter
   import lineq_pkg::*;
#(
   parameter int unsigned MIN_LEN   = 1000,
   parameter int unsigned SHORT_MAX = 1360,
   parameter int unsigned MAX_LEN   = 1500
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      edge_i,
   input  logic      en_i,
   output line_evt_t evt_o
);

   localparam int unsigned SAT_VAL = MAX_LEN + 1;
   localparam int unsigned CW      = bits_for(SAT_VAL);
   localparam logic [CW-1:0] MIN_C   = CW'(MIN_LEN);
   localparam logic [CW-1:0] SHORT_C = CW'(SHORT_MAX);
   localparam logic [CW-1:0] MAX_C   = CW'(MAX_LEN);
   localparam logic [CW-1:0] SAT_C   = CW'(SAT_VAL);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_now;
   logic          armed_q;
   logic          in_range;

   // Only edges on which the downstream system advances are counted
   always_comb begin
      if (en_i && (cnt_q != SAT_C)) len_now = cnt_q + CW'(1);
      else                          len_now = cnt_q;
   end

   assign in_range = (len_now >= MIN_C) && (len_now <= MAX_C);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (edge_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else begin
         cnt_q   <= len_now;
      end
   end

   always_comb begin
      evt_o.done   = edge_i;
      evt_o.valid  = edge_i && armed_q && in_range;
      evt_o.shortl = edge_i && armed_q && in_range && (len_now <= SHORT_C);
   end

   // R2: a frozen downstream leaves the measurement untouched
   p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !edge_i) |=> (cnt_q == $past(cnt_q)));

   // R6: every sampled boundary arms the measurement for the next line
   p_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_i |=> armed_q);

endmodule

// File: rtl/lineq_stall.sv
module lineq_stall
   import lineq_pkg::*;
#(
   parameter int unsigned STALL_TICKS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bypass_i,
   input  logic short_i,
   output logic en_o,
   output logic active_o,
   output logic start_o
);

   localparam int unsigned SW = bits_for(STALL_TICKS);
   localparam logic [SW-1:0] LOAD_C = SW'(STALL_TICKS);

   logic [SW-1:0] left_q;
   logic [SW-1:0] left_d;
   logic          en_q;

   // A stall in progress is never restarted or stretched
   assign start_o = !bypass_i && (left_q == '0) && short_i;

   always_comb begin
      if (bypass_i)           left_d = '0;
      else if (left_q != '0)  left_d = left_q - SW'(1);
      else if (start_o)       left_d = LOAD_C;
      else                    left_d = '0;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         left_q <= '0;
         en_q   <= 1'b1;
      end else begin
         left_q <= left_d;
         en_q   <= (left_d == '0);
      end
   end

   assign en_o     = en_q;
   assign active_o = (left_q != '0);

   // R4: the stall window counts down by one tick per cycle
   p_countdown_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && !bypass_i) |=> (left_q == $past(left_q) - SW'(1)));

   // R5: the flag and the enable agree in every cycle
   p_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_o == !en_o);

   // R9: a sampled bypass leaves the enable high
   p_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(bypass_i) |-> en_o);

   // R3: a stall only begins after a short line was reported
   p_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_o) |-> $past(short_i));

endmodule

// File: rtl/lineq_tally.sv
module lineq_tally #(
   parameter int unsigned W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);

   localparam logic [W-1:0] TOP_C = '1;

   logic [W-1:0] count_q;
   logic [W-1:0] count_d;

   always_comb begin
      if (clear_i)                          count_d = inc_i ? W'(1) : '0;
      else if (inc_i && (count_q != TOP_C)) count_d = count_q + W'(1);
      else                                  count_d = count_q;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) count_q <= '0;
      else         count_q <= count_d;
   end

   assign count_o = count_q;

   // R10: after a frame boundary at most the same-edge correction remains
   p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (count_o <= W'(1)));

   // R10: without a clear the tally only holds or steps up by one
   p_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + W'(1))));

endmodule

// File: rtl/short_line_equalizer.sv
module short_line_equalizer
   import lineq_pkg::*;
#(
   parameter int unsigned MIN_LEN     = 1000,
   parameter int unsigned SHORT_MAX   = 1360,
   parameter int unsigned MAX_LEN     = 1500,
   parameter int unsigned STALL_TICKS = 4,
   parameter int unsigned TALLY_W     = 4,
   parameter bit          SYNC_FALL   = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hsync_i,
   input  logic               vsync_i,
   input  logic               bypass_i,
   output logic               clk_en_o,
   output logic               stall_o,
   output logic [TALLY_W-1:0] fix_count_o
);

   generate
      if ((MIN_LEN > SHORT_MAX) || (SHORT_MAX >= MAX_LEN)) begin : g_bad_range
         $error("length window must satisfy MIN_LEN <= SHORT_MAX < MAX_LEN");
      end
      if (STALL_TICKS < 1) begin : g_bad_stall
         $error("STALL_TICKS must be at least 1");
      end
      if (TALLY_W < 1) begin : g_bad_tally
         $error("TALLY_W must be at least 1");
      end
   endgenerate

   logic      h_edge;
   logic      v_edge;
   logic      en;
   logic      start;
   line_evt_t evt;

   lineq_edge #(.FALLING(SYNC_FALL)) u_h_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (hsync_i),
      .edge_o (h_edge)
   );

   lineq_edge #(.FALLING(SYNC_FALL)) u_v_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (vsync_i),
      .edge_o (v_edge)
   );

   lineq_meter #(
      .MIN_LEN   (MIN_LEN),
      .SHORT_MAX (SHORT_MAX),
      .MAX_LEN   (MAX_LEN)
   ) u_meter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .edge_i (h_edge),
      .en_i   (en),
      .evt_o  (evt)
   );

   lineq_stall #(.STALL_TICKS(STALL_TICKS)) u_stall (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bypass_i (bypass_i),
      .short_i  (evt.shortl),
      .en_o     (en),
      .active_o (stall_o),
      .start_o  (start)
   );

   lineq_tally #(.W(TALLY_W)) u_tally (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (v_edge),
      .inc_i   (start),
      .count_o (fix_count_o)
   );

   assign clk_en_o = en;

endmodule

// File: tb/test_short_line_equalizer.sv
module test_short_line_equalizer;

   localparam int SYNC_W = 100;
   localparam int WATCHDOG = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b1;
   logic       vsync = 1'b1;
   logic       bypass = 1'b0;
   logic       clk_en;
   logic       stall;
   logic [3:0] fix_count;

   int  checks = 0;
   int  errors = 0;
   int  exp_cnt = 0;
   int  prev_len = 0;
   int  cycles = 0;
   bit  armed = 1'b0;
   bit  done = 1'b0;

   short_line_equalizer i_short_line_equalizer (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .hsync_i     (hsync),
      .vsync_i     (vsync),
      .bypass_i    (bypass),
      .clk_en_o    (clk_en),
      .stall_o     (stall),
      .fix_count_o (fix_count)
   );

   always #10 clk = ~clk;

   function automatic bit is_short(input int len, input bit arm);
      return arm && (len >= 1000) && (len <= 1360);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Plays the downstream system for one line: it drops hsync now, then
   // advances only on enabled edges until len ticks have passed.
   task automatic run_line(input int len, input int byp_cyc, input bit vs_pulse, input string req);
      bit stall_exp;
      bit exp_en;
      bit en_s;
      int ticks;
      int cyc;
      int bad;
      stall_exp = !bypass && is_short(prev_len, armed);
      ticks = 0;
      cyc = 0;
      bad = 0;
      hsync = 1'b0;
      while (ticks < len) begin
         @(negedge clk);
         exp_en = !(stall_exp && (cyc >= 1) && (cyc <= 4) && !((byp_cyc > 0) && (cyc > byp_cyc)));
         if ((clk_en !== exp_en) || (stall !== !exp_en)) bad++;
         en_s = clk_en;
         @(posedge clk);
         #1;
         cyc++;
         if (en_s) begin
            ticks++;
            if (ticks == SYNC_W) hsync = 1'b1;
         end
         if ((byp_cyc > 0) && (cyc == byp_cyc)) bypass = 1'b1;
         if (vs_pulse && (cyc == 20)) vsync = 1'b0;
         if (vs_pulse && (cyc == 23)) vsync = 1'b1;
      end
      // mismatching cycles in the enable and flag pattern of this line
      check(bad == 0, req, bad, 0);
      if (stall_exp && (exp_cnt < 15)) exp_cnt++;
      if (vs_pulse) exp_cnt = 0;
      check(fix_count == 4'(exp_cnt), "R10", int'(fix_count), exp_cnt);
      armed = 1'b1;
      prev_len = len;
   endtask

   always @(posedge clk) begin
      cycles++;
      if ((cycles > WATCHDOG) && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      int len;
      int pick;
      seed_init = $urandom(32'h5eed1360);

      // R1: reset state
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(clk_en === 1'b1, "R1", int'(clk_en), 1);
      check(stall === 1'b0, "R1", int'(stall), 0);
      check(fix_count === 4'd0, "R1", int'(fix_count), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // Partial line before the first edge: long enough to look short if counted
      repeat (1200) @(posedge clk);
      #1;

      run_line(1360, 0, 1'b0, "R6");          // first edge only arms
      run_line(1364, 0, 1'b0, "R3 R4 R5");    // ends a 1360 line
      run_line(1360, 0, 1'b0, "R7");          // ends a 1364 line
      run_line(1358, 0, 1'b0, "R3 R4 R5");    // ends a 1360 line
      run_line(1364, 0, 1'b0, "R2");          // 1358 after a stall is still short
      run_line(1361, 0, 1'b0, "R7");          // ends 1364
      run_line(1000, 0, 1'b0, "R7");          // ends 1361, upper boundary
      run_line(999, 0, 1'b0, "R3");           // ends 1000, lower boundary
      run_line(1500, 0, 1'b0, "R8");          // ends 999
      run_line(1501, 0, 1'b1, "R7");          // ends 1500, frame boundary
      run_line(500, 0, 1'b0, "R8");           // ends 1501
      run_line(1360, 0, 1'b0, "R8");          // ends a 500 glitch
      run_line(1364, 3, 1'b0, "R9");          // stall cut short by bypass
      run_line(1360, 0, 1'b0, "R9");          // bypass held
      run_line(1364, 0, 1'b0, "R9");          // short line ignored under bypass
      bypass = 1'b0;
      run_line(1364, 0, 1'b1, "R10");         // ends 1364, frame boundary

      for (int i = 0; i < 40; i++) begin
         pick = int'($urandom % 8);
         if (pick < 4)       len = 1364;
         else if (pick < 6)  len = 1360;
         else if (pick == 6) len = 1000 + int'($urandom % 501);
         else                len = 600 + int'($urandom % 1200);
         run_line(len, 0, (i % 8) == 7, "R3 R7 R8");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule